// File: doc/BRIEF.md
# Masked Base Address Register

This block holds one base address register of a configuration header. Software writes it through a plain write port with per-byte enables and reads it back combinationally. A per-instance configuration word, fixed at elaboration, splits the register into two parts. The upper part is a mask of the address bits that software may change, and that mask also sets the size of the decoded window. The lowest bits are attribute bits with constant read values. Memory windows have four attribute bits and I/O windows have two.

A third kind models an expansion-ROM register. Its window size comes from a byte count, which is rounded up to a power of two with a floor of 2 KB. Software can change only bit 0, the decode enable, and the address bits at or above the rounded size. To size a window, software writes all ones and reads back the result. The zero bits above the attribute field give the window size in two's-complement form.

Writes take effect at the rising clock edge where `wr_en` is high. The read port shows the new value from the next cycle on. There is no stream data path, so the port has no valid/ready handshake and no back-pressure. A write is accepted in the cycle it is presented.

Top module: `bar_reg_masked`

## Requirements
- R1: For a memory kind (KIND=0), read bits [3:0] always equal CFG[3:0]. For an I/O kind (KIND=1), read bits [1:0] always equal CFG[1:0]. No write ever changes these bits.
- R2: For memory and I/O kinds, a write changes exactly the address bits that are set in CFG above the attribute field. Every other bit reads back as its fixed value or zero, so writing all ones reads back CFG itself.
- R3: An I/O kind with CFG[1:0] = 2'b11 reads back bit 1 as set, even though that bit is normally reserved.
- R4: After reset, the stored address bits equal RST_VAL masked by the writable bits, and the ROM enable bit reads 0. An I/O kind with CFG = 0xFFFFFFFF and RST_VAL = 0x84000000 reads 0x84000003.
- R5: Byte lane k (bits 8k+7..8k) takes wr_data for that lane only when wr_be[k] is 1. The writable mask still applies. When wr_be is all zero, the register does not change.
- R6: For the ROM kind (KIND=2), the only writable bits are bit 0 (the enable) and the bits at or above the rounded window size. All other bits read 0.
- R7: The ROM window size is ROM_BYTES rounded up to a power of two, with a minimum of 2048. ROM_BYTES=5000 gives a read of 0xFFFFE001 after writing all ones. ROM_BYTES=100 gives 0xFFFFF801.
- R8: While wr_en is 0, the read value does not change, whatever wr_data and wr_be hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for this register |
| wr_be | input | W/8 | Per-byte write enables |
| wr_data | input | W | Write data |
| rd_data | output | W | Current register value as software sees it |

## Verification
The bench builds four instances at W=32, all driven from one write bus.

The first is an I/O register with every bit above bit 1 writable, fixed low bits 2'b11 and a nonzero reset value. This covers the reserved-bit-set readback and a nonzero reset.

The second is a memory register with a 64 KB window and a fixed prefetch-style attribute. Writes aimed at its low, read-only bytes show that those bytes never change.

The third and fourth are ROM registers with byte counts of 5000 and 100. They exercise the round-up to 8 KB and the 2 KB floor, and a later reset shows that it clears the enable bit.

// File: rtl/bar_pkg.sv
package bar_pkg;

  typedef enum logic [1:0] {
    BAR_MEM = 2'd0,
    BAR_IO  = 2'd1,
    BAR_ROM = 2'd2
  } bar_kind_e;

  // Round a byte count up to a power of two, never below 2 KB.
  function automatic logic [63:0] rom_span(input logic [63:0] bytes);
    logic [63:0] s;
    s = 64'd2048;
    for (int i = 0; i < 64; i++) begin
      if (s < bytes) s = s << 1;
    end
    return s;
  endfunction

  function automatic int attr_width(input bar_kind_e k);
    case (k)
      BAR_MEM: return 4;
      BAR_IO:  return 2;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/bar_mask_gen.sv
module bar_mask_gen #(
  parameter int                W         = 32,
  parameter bar_pkg::bar_kind_e KIND     = bar_pkg::BAR_MEM,
  parameter logic [W-1:0]      CFG       = '0,
  parameter logic [63:0]       ROM_BYTES = 64'd2048
) (
  output logic [W-1:0] wmask,
  output logic [W-1:0] fixed_bits
);
  import bar_pkg::*;

  localparam int           AW       = attr_width(KIND);
  localparam logic [W-1:0] ATTR_SEL = {{(W-AW){1'b0}}, {AW{1'b1}}};
  localparam logic [63:0]  SPAN     = rom_span(ROM_BYTES);
  localparam logic [W-1:0] SPAN_W   = SPAN[W-1:0];

  generate
    if (KIND == BAR_ROM) begin : g_rom
      assign wmask      = ~(SPAN_W - {{(W-1){1'b0}}, 1'b1}) | {{(W-1){1'b0}}, 1'b1};
      assign fixed_bits = '0;
    end else begin : g_addr
      assign wmask      = CFG & ~ATTR_SEL;
      assign fixed_bits = CFG & ATTR_SEL;
    end
  endgenerate

endmodule

// File: rtl/bar_byte_lane.sv
module bar_byte_lane #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [LW-1:0] m,
  input  logic [LW-1:0] d,
  input  logic [LW-1:0] rv,
  output logic [LW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= rv & m;
    else if (we) q <= (q & ~m) | (d & m);
  end

  // R5 / R8: a lane without its enable keeps its value
  assert_lane_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

  // R2: a lane never holds a bit outside its writable mask
  assert_lane_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & ~m) == '0));

endmodule

// File: rtl/bar_reg_masked.sv
module bar_reg_masked #(
  parameter int                 W         = 32,
  parameter bar_pkg::bar_kind_e KIND      = bar_pkg::BAR_MEM,
  parameter logic [W-1:0]       CFG       = 32'hFFFF_0000,
  parameter logic [W-1:0]       RST_VAL   = '0,
  parameter logic [63:0]        ROM_BYTES = 64'd2048
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [W/8-1:0] wr_be,
  input  logic [W-1:0]   wr_data,
  output logic [W-1:0]   rd_data
);
  import bar_pkg::*;

  localparam int LANES = W / 8;

  logic [W-1:0] wmask;
  logic [W-1:0] fixed_bits;
  logic [W-1:0] stored;
  logic [W-1:0] rst_eff;

  // The ROM enable always clears on reset.
  assign rst_eff = (KIND == BAR_ROM) ? (RST_VAL & ~{{(W-1){1'b0}}, 1'b1}) : RST_VAL;

  bar_mask_gen #(
    .W(W), .KIND(KIND), .CFG(CFG), .ROM_BYTES(ROM_BYTES)
  ) mask_i (
    .wmask(wmask),
    .fixed_bits(fixed_bits)
  );

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      bar_byte_lane #(.LW(8)) lane_i (
        .clk(clk),
        .rst_n(rst_n),
        .we(wr_en & wr_be[k]),
        .m(wmask[8*k +: 8]),
        .d(wr_data[8*k +: 8]),
        .rv(rst_eff[8*k +: 8]),
        .q(stored[8*k +: 8])
      );
    end
  endgenerate

  assign rd_data = stored | fixed_bits;

  // R1: attribute bits always read their fixed values
  assert_fixed_attr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~wmask) == fixed_bits);

  // R2: a full-width write lands on every writable bit
  assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (&wr_be)) |=> ((rd_data & wmask) == ($past(wr_data) & wmask)));

  // R8: no strobe, no change at the read port
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  generate
    if (KIND == BAR_ROM && W >= 12) begin : g_rom_chk
      // R6 / R7: bits between the enable and the 2 KB floor always read zero
      assert_rom_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[10:1] == '0);
    end
  endgenerate

endmodule

// File: tb/bar_reg_masked_tb.sv
module bar_reg_masked_tb_top;
  import bar_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  wr_en = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd [4];
  logic [31:0] rd0, rd1, rd2, rd3;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  bar_reg_masked #(.W(32), .KIND(BAR_IO), .CFG(32'hFFFF_FFFF), .RST_VAL(32'h8400_0000))
    dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en[0]), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd0));
  bar_reg_masked #(.W(32), .KIND(BAR_MEM), .CFG(32'hFFFF_0008))
    mem_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en[1]), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd1));
  bar_reg_masked #(.W(32), .KIND(BAR_ROM), .ROM_BYTES(64'd5000))
    rom8k_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en[2]), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd2));
  bar_reg_masked #(.W(32), .KIND(BAR_ROM), .ROM_BYTES(64'd100))
    rom2k_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en[3]), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd3));

  assign rd[0] = rd0;
  assign rd[1] = rd1;
  assign rd[2] = rd2;
  assign rd[3] = rd3;

  // {select, byte enables, write data, expected read}
  localparam logic [69:0] VEC [12] = '{
    {2'd0, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R2 R3
    {2'd0, 4'hF, 32'h0000_0000, 32'h0000_0003},  // R1 R3
    {2'd0, 4'h4, 32'hAABB_CCDD, 32'h00BB_0003},  // R5
    {2'd0, 4'h1, 32'hAABB_CCDD, 32'h00BB_00DF},  // R5 R1
    {2'd1, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_0008},  // R2
    {2'd1, 4'hF, 32'h1234_5678, 32'h1234_0008},  // R2
    {2'd1, 4'h3, 32'hFFFF_FFFF, 32'h1234_0008},  // R1
    {2'd2, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_E001},  // R6 R7
    {2'd2, 4'hF, 32'h0000_0000, 32'h0000_0000},  // R6
    {2'd2, 4'h1, 32'h0000_0001, 32'h0000_0001},  // R6
    {2'd3, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_F801},  // R7
    {2'd3, 4'h0, 32'h0000_0000, 32'hFFFF_F801}   // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en   = 4'b0001 << sel;
    wr_be   = be;
    wr_data = d;
    @(negedge clk);
    wr_en = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 io reset", rd[0], 32'h8400_0003);
    check("R4 mem reset", rd[1], 32'h0000_0008);
    check("R4 rom reset", rd[2], 32'h0000_0000);
    check("R4 rom2k reset", rd[3], 32'h0000_0000);

    for (int i = 0; i < 12; i++) begin
      do_write(VEC[i][69:68], VEC[i][67:64], VEC[i][63:32]);
      check($sformatf("R1/R2/R5/R6/R7 vector %0d", i), rd[VEC[i][69:68]], VEC[i][31:0]);
    end

    // R8: data and enables toggle without the strobe
    @(negedge clk);
    wr_be = 4'hF;
    wr_data = 32'h5555_AAAA;
    @(negedge clk);
    @(negedge clk);
    check("R8 io idle", rd[0], 32'h00BB_00DF);
    check("R8 mem idle", rd[1], 32'h1234_0008);

    // R4: reset again clears address bits and the ROM enable
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 io re-reset", rd[0], 32'h8400_0003);
    check("R4 rom enable cleared", rd[2], 32'h0000_0000);
    check("R4 rom2k re-reset", rd[3], 32'h0000_0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule